// File: doc/BRIEF.md
# Dual-Channel Instruction Address Breakpoint

This block sits beside the fetch/decode stage of a small processor core and watches the start of every instruction. Two watch channels each hold a target instruction address and an enable bit. When the core signals that an instruction is about to begin, the block compares that instruction's address with every enabled channel. On a hit it raises an interrupt request in the same cycle, so the core can take the break before the instruction runs. The request does not pass through the core's global interrupt mask or its priority level; the block has no input for either.

Along with the request, the block reports which channel fired and the program-counter value the core should push on the stack. That value is not the true return address. It is the channel's target address plus 2 when the decoder marks the instruction as a long-opcode or special short-form instruction, and plus 1 otherwise. Software reprograms the channels through a small write-only register port. If both channels hit the same instruction, the lower-numbered channel is reported and only one request is raised.

Top module: `addr_break_unit`

## Requirements
- R1: After reset all target addresses and all enable bits are zero: no request occurs until an enable is written, and once channel 0 is enabled with its target left unwritten, an instruction start at address 0 fires channel 0.
- R2: While `instr_start` is high and an enabled channel's target equals `instr_addr`, `brk_req` is high in that same cycle.
- R3: A channel whose enable bit is clear never raises a request, even when its target equals `instr_addr`.
- R4: `brk_req` is low in every cycle in which `instr_start` is low, whatever the address and the register contents.
- R5: When both channels hit the same instruction, `brk_chan` reads 0 and a single request is raised.
- R6: With `wide_op` = 1 during the hit, `stack_pc` equals the target address plus 2.
- R7: With `wide_op` = 0 during the hit, `stack_pc` equals the target address plus 1.
- R8: The `stack_pc` sum wraps modulo 2^ADDR_W. With the default width, target 0xFFFFF gives 0x00000 (+1) or 0x00001 (+2), and target 0xFFFFE with +2 gives 0x00000.
- R9: A register write lands at the clock edge that ends its cycle. An instruction start in the same cycle as a write still uses the old enable and target values, and the next instruction start uses the new ones.
- R10: The register port decodes `cfg_sel` as follows: 0 writes the enable bits (bit k of `cfg_data` enables channel k), and k+1 writes channel k's target from `cfg_data`. Any other select value changes nothing.
- R11: While `brk_req` is low, `brk_chan` and `stack_pc` are both zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | SEL_W (2) | Register select: 0 = enables, k+1 = channel k target |
| cfg_data | input | ADDR_W (20) | Write data |
| instr_start | input | 1 | An instruction begins this cycle |
| instr_addr | input | ADDR_W (20) | Address of the first byte of that instruction |
| wide_op | input | 1 | Decoder class: 1 selects the +2 stacked-PC offset |
| brk_req | output | 1 | Break interrupt request, one cycle, aligned with `instr_start` |
| brk_chan | output | CH_W (1) | Index of the channel that fired |
| stack_pc | output | ADDR_W (20) | PC value to push for this break |

## Verification
The bench builds the block with its default parameters: 20-bit addresses and two channels. The 20-bit width puts the wrap points 0xFFFFE and 0xFFFFF within reach of a few directed writes. Two channels are the smallest count that exercises the lowest-index priority rule. The same-cycle write-versus-start case, the unused select code 3 and the reset-zero targets are each driven on purpose rather than left to chance.

// File: rtl/abu_pkg.sv
package abu_pkg;

  // Select code of the enable register; channel k target sits at code k+1.
  localparam int unsigned SEL_ENABLES = 0;
  localparam int unsigned SEL_TARGET0 = 1;

  // Offset added to the target address to form the stacked PC.
  function automatic logic [1:0] pc_step(input logic wide);
    return wide ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/abu_regs.sv
module abu_regs #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [SEL_W-1:0]              cfg_sel,
  input  logic [ADDR_W-1:0]             cfg_data,
  output logic [NUM_CH-1:0]             en_q,
  output logic [NUM_CH-1:0][ADDR_W-1:0] target_q
);
  import abu_pkg::*;

  logic en_wr;
  assign en_wr = cfg_we && (cfg_sel == SEL_W'(SEL_ENABLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= cfg_data[NUM_CH-1:0];
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_target
    logic tgt_wr;
    assign tgt_wr = cfg_we && (cfg_sel == SEL_W'(SEL_TARGET0 + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      target_q[k] <= '0;
      else if (tgt_wr) target_q[k] <= cfg_data;
    end
  end

endmodule

// File: rtl/abu_cmp.sv
module abu_cmp #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              instr_start,
  input  logic [ADDR_W-1:0] instr_addr,
  input  logic              enable,
  input  logic [ADDR_W-1:0] target,
  output logic              hit
);
  logic addr_eq;
  assign addr_eq = (instr_addr == target);
  assign hit     = instr_start && enable && addr_eq;
endmodule

// File: rtl/abu_arb.sv
module abu_arb #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CH_W   = 1
) (
  input  logic [NUM_CH-1:0] hit_vec,
  output logic              any_hit,
  output logic [CH_W-1:0]   win_idx
);
  assign any_hit = |hit_vec;

  // Scan from the top down so the lowest hitting index is left standing.
  always_comb begin
    win_idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = CH_W'(i);
    end
  end
endmodule

// File: rtl/abu_pcgen.sv
module abu_pcgen #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] base,
  input  logic              wide,
  output logic [ADDR_W-1:0] pc
);
  import abu_pkg::*;
  // Width-truncated sum: wraps modulo 2^ADDR_W.
  assign pc = base + ADDR_W'(pc_step(wide));
endmodule

// File: rtl/addr_break_unit.sv
module addr_break_unit #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned SEL_W = $clog2(NUM_CH + 1),
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              instr_start,
  input  logic [ADDR_W-1:0] instr_addr,
  input  logic              wide_op,
  output logic              brk_req,
  output logic [CH_W-1:0]   brk_chan,
  output logic [ADDR_W-1:0] stack_pc
);

  logic [NUM_CH-1:0]             en_q;
  logic [NUM_CH-1:0][ADDR_W-1:0] target_q;
  logic [NUM_CH-1:0]             hit_vec;
  logic                          any_hit;
  logic [CH_W-1:0]               win_idx;
  logic [ADDR_W-1:0]             win_target;
  logic [ADDR_W-1:0]             raw_pc;

  abu_regs #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .en_q     (en_q),
    .target_q (target_q)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    abu_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .instr_start (instr_start),
      .instr_addr  (instr_addr),
      .enable      (en_q[k]),
      .target      (target_q[k]),
      .hit         (hit_vec[k])
    );
  end

  abu_arb #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_arb (
    .hit_vec (hit_vec),
    .any_hit (any_hit),
    .win_idx (win_idx)
  );

  assign win_target = target_q[win_idx];

  abu_pcgen #(.ADDR_W(ADDR_W)) u_pcgen (
    .base (win_target),
    .wide (wide_op),
    .pc   (raw_pc)
  );

  assign brk_req  = any_hit;
  assign brk_chan = any_hit ? win_idx : '0;
  assign stack_pc = any_hit ? raw_pc  : '0;

endmodule

// File: rtl/abu_chk.sv
module abu_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CH_W   = 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          instr_start,
  input logic [ADDR_W-1:0]             instr_addr,
  input logic                          wide_op,
  input logic                          brk_req,
  input logic [CH_W-1:0]               brk_chan,
  input logic [ADDR_W-1:0]             stack_pc,
  input logic [NUM_CH-1:0]             en_q,
  input logic [NUM_CH-1:0][ADDR_W-1:0] target_q
);

  logic            exp_any;
  logic [CH_W-1:0] exp_chan;
  always_comb begin
    exp_any  = 1'b0;
    exp_chan = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!exp_any && en_q[i] && target_q[i] == instr_addr) begin
        exp_any  = 1'b1;
        exp_chan = CH_W'(i);
      end
    end
  end

  logic [ADDR_W:0] wide_sum;
  assign wide_sum = {1'b0, target_q[brk_chan]} + (wide_op ? (ADDR_W+1)'(2) : (ADDR_W+1)'(1));

  // R4
  no_stray_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_start |-> !brk_req);

  // R2
  req_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_start && exp_any) |-> brk_req);

  // R3
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (en_q[brk_chan] && target_q[brk_chan] == instr_addr));

  // R5
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (brk_chan == exp_chan));

  // R6 R7 R8
  stacked_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (stack_pc == wide_sum[ADDR_W-1:0]));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_req |-> (brk_chan == '0 && stack_pc == '0));

endmodule

bind addr_break_unit abu_chk #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_start (instr_start),
  .instr_addr  (instr_addr),
  .wide_op     (wide_op),
  .brk_req     (brk_req),
  .brk_chan    (brk_chan),
  .stack_pc    (stack_pc),
  .en_q        (en_q),
  .target_q    (target_q)
);

// File: tb/addr_break_unit_tb.sv
module addr_break_unit_tb;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_data = '0;
  logic          instr_start = 1'b0;
  logic [AW-1:0] instr_addr = '0;
  logic          wide_op = 1'b0;
  logic          brk_req;
  logic          brk_chan;
  logic [AW-1:0] stack_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  addr_break_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .instr_start(instr_start), .instr_addr(instr_addr), .wide_op(wide_op),
    .brk_req(brk_req), .brk_chan(brk_chan), .stack_pc(stack_pc)
  );

  function automatic logic [AW-1:0] want_pc(input logic [AW-1:0] t, input bit w);
    logic [AW:0] s;
    s = {1'b0, t} + (w ? 21'd2 : 21'd1);
    return s[AW-1:0];
  endfunction

  task automatic expect_out(input string tag, input bit er, input bit ec, input logic [AW-1:0] ep);
    checks++;
    if (brk_req !== er || brk_chan !== ec || stack_pc !== ep) begin
      errors++;
      $display("FAIL %s: req/chan/pc actual=%0b/%0d/%05h expected=%0b/%0d/%05h",
               tag, brk_req, brk_chan, stack_pc, er, ec, ep);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One instruction start, checked in its own cycle before the next edge.
  task automatic probe(input string tag, input logic [AW-1:0] a, input bit w,
                       input bit er, input bit ec, input logic [AW-1:0] ep);
    @(negedge clk);
    instr_start = 1'b1; instr_addr = a; wide_op = w;
    #2 expect_out(tag, er, ec, ep);
    @(posedge clk); #1;
    instr_start = 1'b0;
  endtask

  task automatic t_reset;
    expect_out("R1 reset idle", 0, 0, '0);
    probe("R1 no enables at addr 0", '0, 0, 0, 0, '0);
    wr(2'd0, 20'h1);
    probe("R1 target0 reset to zero", '0, 0, 1, 0, 20'h00001);
    wr(2'd0, 20'h0);
  endtask

  task automatic t_basic;
    wr(2'd1, 20'h12340);
    wr(2'd2, 20'h0ABCD);
    wr(2'd0, 20'h3);
    probe("R2 R7 ch0 hit narrow", 20'h12340, 0, 1, 0, want_pc(20'h12340, 0));
    probe("R2 R6 ch1 hit wide", 20'h0ABCD, 1, 1, 1, want_pc(20'h0ABCD, 1));
    probe("R2 miss other address", 20'h12341, 0, 0, 0, '0);
    @(negedge clk);
    instr_start = 1'b0; instr_addr = 20'h12340;
    #2 expect_out("R4 R11 no strobe no req", 0, 0, '0);
  endtask

  task automatic t_disable;
    wr(2'd0, 20'h2);
    probe("R3 ch0 disabled ignored", 20'h12340, 1, 0, 0, '0);
    probe("R3 ch1 still enabled", 20'h0ABCD, 0, 1, 1, want_pc(20'h0ABCD, 0));
    wr(2'd0, 20'h0);
    probe("R3 ch1 disabled ignored", 20'h0ABCD, 0, 0, 0, '0);
  endtask

  task automatic t_priority;
    wr(2'd1, 20'h55555);
    wr(2'd2, 20'h55555);
    wr(2'd0, 20'h3);
    probe("R5 both hit ch0 wins", 20'h55555, 1, 1, 0, want_pc(20'h55555, 1));
    wr(2'd0, 20'h2);
    probe("R5 only ch1 enabled", 20'h55555, 0, 1, 1, want_pc(20'h55555, 0));
  endtask

  task automatic t_wrap;
    wr(2'd1, 20'hFFFFF);
    wr(2'd2, 20'hFFFFE);
    wr(2'd0, 20'h3);
    probe("R8 FFFFF +1", 20'hFFFFF, 0, 1, 0, 20'h00000);
    probe("R8 FFFFF +2", 20'hFFFFF, 1, 1, 0, 20'h00001);
    probe("R8 FFFFE +2", 20'hFFFFE, 1, 1, 1, 20'h00000);
  endtask

  task automatic t_same_cycle;
    wr(2'd0, 20'h0);
    wr(2'd1, 20'h00777);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_data = 20'h1;
    instr_start = 1'b1; instr_addr = 20'h00777; wide_op = 1'b0;
    #2 expect_out("R9 write same cycle uses old enable", 0, 0, '0);
    @(posedge clk); #1;
    cfg_we = 1'b0; instr_start = 1'b0;
    probe("R9 next start uses new enable", 20'h00777, 0, 1, 0, 20'h00778);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_data = 20'h00900;
    instr_start = 1'b1; instr_addr = 20'h00777;
    #2 expect_out("R9 target write same cycle uses old target", 1, 0, 20'h00778);
    @(posedge clk); #1;
    cfg_we = 1'b0; instr_start = 1'b0;
    probe("R9 new target active", 20'h00900, 1, 1, 0, 20'h00902);
  endtask

  task automatic t_bad_sel;
    wr(2'd3, 20'h00777);
    probe("R10 sel 3 leaves ch0 target", 20'h00900, 0, 1, 0, 20'h00901);
    probe("R10 sel 3 wrote nothing", 20'h00777, 0, 0, 0, '0);
    wr(2'd0, 20'hFFFFE);
    probe("R10 enable bit0 from data bit0", 20'h00900, 0, 0, 0, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_disable();
    t_priority();
    t_wrap();
    t_same_cycle();
    t_bad_sel();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule